// File: doc/BRIEF.md
# Saturating 16x16 Multiply-Accumulate Unit

This block multiplies two signed 16-bit operands and adds the 32-bit signed product into an accumulator. The accumulator is held as two 32-bit words: a high word and a low word. A mode input picks one of two ways to accumulate, and it is sampled with each operation.

In saturating mode only the low word takes part in the sum. The sum is clamped to the signed 32-bit range. A clamp sets bit 0 of the high word, and that bit stays set until the accumulator is cleared. In wrapping mode the two words act as one wide signed sum. The carry out of the low word goes into the high word, and the high word is sign-extended from its bit 9, so the sum wraps at 42 bits.

An operation is requested by pulsing the valid strobe with the operands and the mode. The updated words appear on the outputs one clock later. A synchronous clear input zeroes both words.

Top module: `mac_unit`

## Requirements
- R1: While `rst` is high at a rising edge, both accumulator words become zero at that edge.
- R2: `clr` high at a rising edge zeroes both words at that edge, even when `in_valid` is also high.
- R3: With `in_valid` and `clr` both low, both words keep their values.
- R4: The operands are signed two's-complement 16-bit values. With `in_valid` high at a rising edge, the outputs show the new accumulator value right after that edge. Before that edge they still show the old value.
- R5: In saturating mode (`sat_mode` = 1), when the signed 32-bit sum of the low word and the product stays in range, the low word takes the sum and the high word is unchanged.
- R6: In saturating mode, if the sum leaves the signed 32-bit range, the low word takes 0x7FFFFFFF for a non-negative product and 0x80000000 for a negative product.
- R7: In saturating mode, an out-of-range sum sets bit 0 of the high word. That bit stays 1 through later saturating operations. Bits 31:1 of the high word never change in this mode.
- R8: In wrapping mode (`sat_mode` = 0), the low word takes the low 32 bits of the low word plus the product. The high word adds the sign extension of the product and the carry out of the low word. Taken together, {high[9:0], low} behaves as a 42-bit signed accumulator.
- R9: After a wrapping-mode operation, bits 31:9 of the high word all equal bit 9. A 42-bit overflow therefore wraps the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of both accumulator words |
| in_valid | input | 1 | Requests one multiply-accumulate at this edge |
| sat_mode | input | 1 | 1 = saturating mode, 0 = wrapping mode |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| acc_hi | output | 32 | High accumulator word |
| acc_lo | output | 32 | Low accumulator word |

## Verification
The assertions assume that `clr` and `rst` alone can break the hold and mode rules, and that `sat_mode` is valid in every cycle where `in_valid` is high. They also assume the operands are only meaningful under the strobe. The stimulus drives every input half a cycle away from the sampling edge and keeps `in_valid` as a single-cycle pulse. Between pulses it parks `sat_mode` and the operands at fixed values. It also holds `clr` low during accumulate runs, except in the one directed case where clear and valid collide on purpose.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int OP_W    = 16;
    localparam int ACC_W   = 32;
    localparam int HI_KEEP = 10;

    typedef enum logic {
        MODE_WRAP = 1'b0,
        MODE_SAT  = 1'b1
    } mac_mode_e;

    typedef struct packed {
        logic [ACC_W-1:0] hi;
        logic [ACC_W-1:0] lo;
    } acc_t;

    function automatic logic [ACC_W-1:0] sat_limit(input logic negative);
        logic [ACC_W-1:0] r;
        r = {1'b0, {(ACC_W-1){1'b1}}};
        if (negative) begin
            r = {1'b1, {(ACC_W-1){1'b0}}};
        end
        return r;
    endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int OP_W  = mac_pkg::OP_W,
    parameter int ACC_W = mac_pkg::ACC_W
) (
    input  logic [OP_W-1:0]  mul_a,
    input  logic [OP_W-1:0]  mul_b,
    output logic [ACC_W-1:0] mul_p
);
    localparam int PROD_W = 2 * OP_W;

    logic signed [PROD_W-1:0] prod_raw;
    logic signed [ACC_W-1:0]  prod_ext;

    always_comb begin
        prod_raw = $signed(mul_a) * $signed(mul_b);
        prod_ext = ACC_W'(prod_raw);
        mul_p    = prod_ext;
    end
endmodule

// File: rtl/mac_sat_add.sv
module mac_sat_add #(
    parameter int ACC_W = mac_pkg::ACC_W
) (
    input  logic [ACC_W-1:0] lo_in,
    input  logic [ACC_W-1:0] prod,
    output logic [ACC_W-1:0] lo_out,
    output logic             clamp
);
    localparam int MSB = ACC_W - 1;

    logic [ACC_W-1:0] raw_sum;

    always_comb begin
        raw_sum = lo_in + prod;
        clamp   = (lo_in[MSB] == prod[MSB]) && (raw_sum[MSB] != prod[MSB]);
        lo_out  = clamp ? mac_pkg::sat_limit(prod[MSB]) : raw_sum;
    end
endmodule

// File: rtl/mac_wide_add.sv
module mac_wide_add #(
    parameter int ACC_W   = mac_pkg::ACC_W,
    parameter int HI_KEEP = mac_pkg::HI_KEEP
) (
    input  logic [ACC_W-1:0] hi_in,
    input  logic [ACC_W-1:0] lo_in,
    input  logic [ACC_W-1:0] prod,
    output logic [ACC_W-1:0] hi_out,
    output logic [ACC_W-1:0] lo_out
);
    localparam int MSB  = ACC_W - 1;
    localparam int SBIT = HI_KEEP - 1;

    logic             carry;
    logic [ACC_W-1:0] hi_raw;

    always_comb begin
        {carry, lo_out} = {1'b0, lo_in} + {1'b0, prod};
        hi_raw          = hi_in + {ACC_W{prod[MSB]}} + ACC_W'(carry);
    end

    for (genvar g = 0; g < ACC_W; g++) begin : g_sext
        if (g <= SBIT) begin : g_keep
            assign hi_out[g] = hi_raw[g];
        end else begin : g_fill
            assign hi_out[g] = hi_raw[SBIT];
        end
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
    parameter int OP_W    = mac_pkg::OP_W,
    parameter int ACC_W   = mac_pkg::ACC_W,
    parameter int HI_KEEP = mac_pkg::HI_KEEP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              in_valid,
    input  logic              sat_mode,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [ACC_W-1:0]  acc_hi,
    output logic [ACC_W-1:0]  acc_lo
);
    import mac_pkg::*;

    acc_t             acc_q;
    acc_t             acc_d;
    mac_mode_e        mode;
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] sat_lo;
    logic             sat_clamp;
    logic [ACC_W-1:0] wrap_hi;
    logic [ACC_W-1:0] wrap_lo;

    assign mode = mac_mode_e'(sat_mode);

    mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
        .mul_a (op_a),
        .mul_b (op_b),
        .mul_p (prod)
    );

    mac_sat_add #(.ACC_W(ACC_W)) u_sat (
        .lo_in  (acc_q.lo),
        .prod   (prod),
        .lo_out (sat_lo),
        .clamp  (sat_clamp)
    );

    mac_wide_add #(.ACC_W(ACC_W), .HI_KEEP(HI_KEEP)) u_wide (
        .hi_in  (acc_q.hi),
        .lo_in  (acc_q.lo),
        .prod   (prod),
        .hi_out (wrap_hi),
        .lo_out (wrap_lo)
    );

    always_comb begin
        acc_d = acc_q;
        unique case (mode)
            MODE_SAT: begin
                acc_d.lo    = sat_lo;
                acc_d.hi[0] = acc_q.hi[0] | sat_clamp;
            end
            MODE_WRAP: begin
                acc_d.lo = wrap_lo;
                acc_d.hi = wrap_hi;
            end
            default: acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (in_valid) begin
            acc_q <= acc_d;
        end
    end

    assign acc_hi = acc_q.hi;
    assign acc_lo = acc_q.lo;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int ACC_W   = mac_pkg::ACC_W,
    parameter int HI_KEEP = mac_pkg::HI_KEEP
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             in_valid,
    input logic             sat_mode,
    input logic [ACC_W-1:0] acc_hi,
    input logic [ACC_W-1:0] acc_lo
);
    localparam logic [ACC_W-1:0] POS_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam int UP_W = ACC_W - HI_KEEP + 1;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (acc_hi == '0 && acc_lo == '0));

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_hi == '0 && acc_lo == '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !clr) |=> ($stable(acc_hi) && $stable(acc_lo)));

    // R7
    sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_mode && !clr && acc_hi[0]) |=> acc_hi[0]);

    // R7
    sat_hi_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_mode && !clr) |=> (acc_hi[ACC_W-1:1] == $past(acc_hi[ACC_W-1:1])));

    // R6
    clamp_value_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_mode && !clr && !acc_hi[0]) |=>
            (!acc_hi[0] || acc_lo == POS_MAX || acc_lo == NEG_MIN));

    // R9
    wrap_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !sat_mode && !clr) |=>
            (acc_hi[ACC_W-1:HI_KEEP-1] == {UP_W{1'b0}} ||
             acc_hi[ACC_W-1:HI_KEEP-1] == {UP_W{1'b1}}));
endmodule

bind mac_unit mac_unit_chk #(.ACC_W(ACC_W), .HI_KEEP(HI_KEEP)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .in_valid (in_valid),
    .sat_mode (sat_mode),
    .acc_hi   (acc_hi),
    .acc_lo   (acc_lo)
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic        sat_mode = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [31:0] acc_hi;
    logic [31:0] acc_lo;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] m_hi = '0;
    logic [31:0] m_lo = '0;

    always #4 clk = ~clk;

    mac_unit u0 (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .sat_mode(sat_mode),
        .op_a(op_a), .op_b(op_b), .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    // {sat, a, b, expected hi, expected lo}, applied in order from a cleared accumulator
    localparam logic [96:0] TBL [0:5] = '{
        {1'b0, 16'h0003, 16'h0004, 32'h00000000, 32'h0000000C},
        {1'b0, 16'hFFFE, 16'h0005, 32'h00000000, 32'h00000002},
        {1'b0, 16'hFFFF, 16'h0003, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {1'b1, 16'h7FFF, 16'h7FFF, 32'hFFFFFFFF, 32'h3FFF0000},
        {1'b1, 16'h7FFF, 16'h7FFF, 32'hFFFFFFFF, 32'h7FFE0001},
        {1'b1, 16'h7FFF, 16'h7FFF, 32'hFFFFFFFF, 32'h7FFFFFFF}
    };

    task automatic check(input string tag, input logic [31:0] ghi, input logic [31:0] glo,
                         input logic [31:0] ehi, input logic [31:0] elo);
        n_checks++;
        if (ghi !== ehi || glo !== elo) begin
            n_fail++;
            $display("FAIL %s: got hi=%h lo=%h expected hi=%h lo=%h", tag, ghi, glo, ehi, elo);
        end
    endtask

    // Independent model: saturating via 64-bit range test, wrapping via a 42-bit signed sum
    task automatic model(input logic sat, input logic [15:0] a, input logic [15:0] b);
        longint p;
        longint s;
        logic signed [41:0] v;
        p = longint'($signed(a)) * longint'($signed(b));
        if (sat) begin
            s = longint'($signed(m_lo)) + p;
            if (s > 64'sd2147483647) begin
                m_lo = 32'h7FFFFFFF; m_hi[0] = 1'b1;
            end else if (s < -64'sd2147483648) begin
                m_lo = 32'h80000000; m_hi[0] = 1'b1;
            end else begin
                m_lo = s[31:0];
            end
        end else begin
            v = $signed({m_hi[9:0], m_lo}) + 42'(p);
            m_lo = v[31:0];
            m_hi = {{22{v[41]}}, v[41:32]};
        end
    endtask

    task automatic op(input logic sat, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        in_valid = 1'b1; sat_mode = sat; op_a = a; op_b = b;
        @(negedge clk);
        in_valid = 1'b0; sat_mode = 1'b0; op_a = '0; op_b = '0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        m_hi = '0; m_lo = '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] old_hi;
        logic [31:0] old_lo;
        bit upper_ok;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset", acc_hi, acc_lo, 32'h0, 32'h0);

        // Table walk: R4 R5 R6 R8 R9
        foreach (TBL[i]) begin
            op(TBL[i][96], TBL[i][95:80], TBL[i][79:64]);
            check($sformatf("R8/R5/R6 table %0d", i), acc_hi, acc_lo, TBL[i][63:32], TBL[i][31:0]);
        end

        // R4: latency; old value before the edge, new value after it
        do_clear();
        @(negedge clk);
        in_valid = 1'b1; sat_mode = 1'b0; op_a = 16'h0010; op_b = 16'h0010;
        #1;
        check("R4 before edge", acc_hi, acc_lo, 32'h0, 32'h0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 after edge", acc_hi, acc_lo, 32'h0, 32'h00000100);

        // R6 R7: negative clamp sets the flag
        do_clear();
        repeat (3) begin
            op(1'b1, 16'h8000, 16'h7FFF);
            model(1'b1, 16'h8000, 16'h7FFF);
        end
        check("R6 negative clamp", acc_hi, acc_lo, 32'h00000001, 32'h80000000);

        // R7 R5: flag sticky through an in-range saturating op
        op(1'b1, 16'h0001, 16'h0001);
        check("R7 sticky flag", acc_hi, acc_lo, 32'h00000001, 32'h80000001);

        // R3: idle hold
        repeat (4) @(negedge clk);
        check("R3 idle hold", acc_hi, acc_lo, 32'h00000001, 32'h80000001);

        // R2: clear wins over valid
        @(negedge clk);
        clr = 1'b1; in_valid = 1'b1; sat_mode = 1'b0; op_a = 16'h1234; op_b = 16'h0042;
        @(negedge clk);
        clr = 1'b0; in_valid = 1'b0;
        check("R2 clear over valid", acc_hi, acc_lo, 32'h0, 32'h0);
        m_hi = '0; m_lo = '0;

        // R1: reset mid-stream with valid high
        op(1'b0, 16'h7FFF, 16'h7FFF);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; op_a = 16'h0100; op_b = 16'h0100;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check("R1 reset over valid", acc_hi, acc_lo, 32'h0, 32'h0);
        m_hi = '0; m_lo = '0;

        // R8 R9: long wrapping run that overflows 42 bits
        for (int k = 0; k < 2100; k++) begin
            op(1'b0, 16'h7FFF, 16'h7FFF);
            model(1'b0, 16'h7FFF, 16'h7FFF);
            if (acc_hi !== m_hi || acc_lo !== m_lo)
                check($sformatf("R8 wrap run step %0d", k), acc_hi, acc_lo, m_hi, m_lo);
        end
        check("R8 wrap run end", acc_hi, acc_lo, m_hi, m_lo);
        upper_ok = (acc_hi[31:9] == '1);
        check("R9 sign wrapped negative", {31'b0, upper_ok}, 32'h0, 32'h1, 32'h0);

        // R5 R6 R7 R8 R9: random operands and modes against the model
        do_clear();
        for (int k = 0; k < 600; k++) begin
            logic s;
            logic [15:0] a;
            logic [15:0] b;
            s = $urandom_range(0, 1) == 1;
            a = 16'($urandom);
            b = 16'($urandom);
            if (k % 5 == 0) begin a = 16'h8000; b = 16'h8000; end
            if (k % 97 == 96) do_clear();
            op(s, a, b);
            model(s, a, b);
            check($sformatf("R5/R6/R7/R8/R9 random %0d", k), acc_hi, acc_lo, m_hi, m_lo);
        end

        // R3: hold after random run
        old_hi = acc_hi; old_lo = acc_lo;
        @(negedge clk);
        op_a = 16'h7FFF; op_b = 16'h7FFF; sat_mode = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 operands ignored without valid", acc_hi, acc_lo, old_hi, old_lo);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule